// File: doc/BRIEF.md
# Per-Line Write-Intensity Tracker

This block sits beside the tag array of a set-associative last-level cache built from a fast-write region and a dense, slow-write region. For every cache line it keeps a small saturating activity counter that rises on write hits and falls on read hits. When the fill path installs a line, the counter is preloaded from the one-bit intensity hint recovered from memory, when such a hint exists. When a line is chosen as a victim, the block turns the counter into a fresh one-bit intensity tag. It then decides whether the victim has to go back to memory.

A dirty victim always goes back, carrying its new tag. A clean victim goes back only when its class has flipped since install, so that the stored hint stays current. A configuration input can switch off these clean write-backs altogether. Lookup, replacement and data movement live elsewhere; the line index on every event comes from the external tag array.

Top module: `wi_tracker`

## Requirements
- R1: Each line holds a CNT_W-bit (default 3) counter; a write hit (`hit_is_write`=1) adds one and a read hit subtracts one, saturating at 7 and at 0 with no wrap.
- R2: On eviction `out_wi` is 1 only when the line's counter is strictly greater than `cfg_threshold`; a counter equal to or below the threshold gives 0.
- R3: An install with `inst_known`=1 and `inst_wi`=1 presets the line's counter to 7 and records an installed intensity bit of 1.
- R4: An install with `inst_known`=0, or with `inst_wi`=0, presets the counter to 0 and records an installed intensity bit of 0, whatever the value of `inst_wi`.
- R5: A dirty victim (`evict_dirty`=1) always gives `out_wb_req`=1 with `out_wb_reason`=2'b01, together with its computed `out_wi`.
- R6: A clean victim whose computed bit differs from its installed bit gives `out_wb_req`=1 with `out_wb_reason`=2'b10 when `cfg_clean_wb_en`=1.
- R7: A clean victim whose computed bit equals its installed bit gives `out_wb_req`=0 and `out_wb_reason`=2'b00.
- R8: With `cfg_clean_wb_en`=0 no clean victim ever gives `out_wb_req`=1 (reason 2'b00).
- R9: When a hit and an install name the same line in one cycle, the install preset wins and the hit is discarded.
- R10: The eviction result is registered: `out_valid` and its fields appear on the clock edge after the cycle in which `evict_valid` was high, and `out_valid` is 0 in every other cycle and during reset, with `out_wb_req` low whenever `out_valid` is low.
- R11: Hits and installs change only the line they name; every other line keeps its counter and installed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_threshold | input | CNT_W | Classification threshold |
| cfg_clean_wb_en | input | 1 | Allows write-back of clean victims whose class flipped |
| hit_valid | input | 1 | Hit event strobe |
| hit_line | input | IDX_W | Line index of the hit |
| hit_is_write | input | 1 | 1 for a write hit, 0 for a read hit |
| inst_valid | input | 1 | Install event strobe |
| inst_line | input | IDX_W | Line index being filled |
| inst_wi | input | 1 | Intensity hint carried by the incoming block |
| inst_known | input | 1 | 1 when the hint was recovered from memory |
| evict_valid | input | 1 | Eviction request strobe |
| evict_line | input | IDX_W | Victim line index |
| evict_dirty | input | 1 | Victim is dirty |
| out_valid | output | 1 | Eviction result valid |
| out_wi | output | 1 | Computed intensity bit of the victim |
| out_wb_req | output | 1 | Victim must be written back |
| out_wb_reason | output | 2 | 00 none, 01 dirty, 10 clean with flipped class |

## Verification
Hits and installs take effect at the clock edge of the cycle in which they are presented, so an eviction presented in the following cycle already sees them. The eviction result appears one edge after the request. The bench drives every event just after a falling edge and holds it through one rising edge. It samples the eviction outputs at the next falling edge, which is exactly one registered stage after the request, and checks `out_valid` again one cycle later to confirm that the result lasts a single cycle. A reference array of counters and installed bits, updated by the bench's own rules, supplies the expected tag, request and reason for each eviction.

// File: rtl/wi_pkg.sv
// Package: shared types and helpers for the per-line write-intensity tracker.
// Assumes counters are unsigned and saturate at both ends.
package wi_pkg;

    // Reason code attached to an eviction result; the encoding is decoded downstream.
    typedef enum logic [1:0] {
        WB_NONE       = 2'b00,
        WB_DIRTY      = 2'b01,
        WB_CLEAN_FLIP = 2'b10
    } wb_reason_e;

    // Saturating up/down step of a counter of width w, stored in a 32-bit container.
    function automatic int unsigned sat_step(input int unsigned cur,
                                             input logic        up,
                                             input int unsigned maxv);
        int unsigned nxt;
        if (up) begin
            nxt = (cur >= maxv) ? maxv : cur + 1;
        end else begin
            nxt = (cur == 0) ? 0 : cur - 1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/wi_line_slot.sv
// Module: state for one cache line - a saturating activity counter and the
// intensity bit recorded at install time.
// Assumes at most one hit and one install per cycle; install wins over hit.
module wi_line_slot #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_en,
    input  logic             hit_wr,
    input  logic             inst_en,
    input  logic             inst_high,
    output logic [CNT_W-1:0] cnt,
    output logic             ibit
);
    import wi_pkg::*;

    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    logic [CNT_W-1:0] cnt_step;

    // Next counter value for a hit, saturating at both ends.
    always_comb begin
        cnt_step = CNT_W'(sat_step(int'(cnt), hit_wr, CNT_MAX));
    end

    // Counter and install bit update; install preset takes priority over a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            ibit <= 1'b0;
        end else if (inst_en) begin
            cnt  <= inst_high ? CNT_W'(CNT_MAX) : '0;
            ibit <= inst_high;
        end else if (hit_en) begin
            cnt  <= cnt_step;
        end
    end

endmodule

// File: rtl/wi_counter_bank.sv
// Module: array of per-line slots with index decode for hits and installs,
// and a read port for the victim line.
// Assumes the read port returns the state before this cycle's updates.
module wi_counter_bank #(
    parameter int LINES = 64,
    parameter int CNT_W = 3,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_line,
    input  logic             hit_is_write,
    input  logic             inst_valid,
    input  logic [IDX_W-1:0] inst_line,
    input  logic             inst_high,
    input  logic [IDX_W-1:0] rd_line,
    output logic [CNT_W-1:0] rd_cnt,
    output logic             rd_ibit
);

    logic [CNT_W-1:0] cnt_arr  [LINES];
    logic             ibit_arr [LINES];

    // One slot per line, each decoding its own index.
    for (genvar g = 0; g < LINES; g++) begin : g_slot
        logic hit_sel;
        logic inst_sel;

        // Select strobes for this line.
        always_comb begin
            hit_sel  = hit_valid  && (hit_line  == IDX_W'(g));
            inst_sel = inst_valid && (inst_line == IDX_W'(g));
        end

        wi_line_slot #(
            .CNT_W (CNT_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_en    (hit_sel),
            .hit_wr    (hit_is_write),
            .inst_en   (inst_sel),
            .inst_high (inst_high),
            .cnt       (cnt_arr[g]),
            .ibit      (ibit_arr[g])
        );
    end

    // Victim read mux.
    always_comb begin
        rd_cnt  = cnt_arr[rd_line];
        rd_ibit = ibit_arr[rd_line];
    end

endmodule

// File: rtl/wi_victim_classifier.sv
// Module: combinational eviction decision - threshold compare and write-back
// selection with its reason code.
// Assumes the counter and installed bit belong to the victim line.
module wi_victim_classifier #(
    parameter int CNT_W = 3
) (
    input  logic             [CNT_W-1:0] vic_cnt,
    input  logic                         vic_ibit,
    input  logic                         vic_dirty,
    input  logic             [CNT_W-1:0] threshold,
    input  logic                         clean_wb_en,
    output logic                         wi_bit,
    output logic                         wb_req,
    output wi_pkg::wb_reason_e           reason
);
    import wi_pkg::*;

    // Strict compare: equal to threshold counts as low intensity.
    always_comb begin
        wi_bit = (vic_cnt > threshold);
    end

    // Dirty victims always go back; clean ones only on a class flip when allowed.
    always_comb begin
        if (vic_dirty) begin
            wb_req = 1'b1;
            reason = WB_DIRTY;
        end else if (clean_wb_en && (wi_bit != vic_ibit)) begin
            wb_req = 1'b1;
            reason = WB_CLEAN_FLIP;
        end else begin
            wb_req = 1'b0;
            reason = WB_NONE;
        end
    end

endmodule

// File: rtl/wi_tracker.sv
// Module: per-line write-intensity tracker for a hybrid last-level cache.
// Tracks write/read activity per line, presets it from install hints, and
// produces a registered eviction result one cycle after each request.
// Assumes line indices come from an external tag array and are in range.
module wi_tracker #(
    parameter int LINES = 64,
    parameter int CNT_W = 3,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_threshold,
    input  logic             cfg_clean_wb_en,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_line,
    input  logic             hit_is_write,
    input  logic             inst_valid,
    input  logic [IDX_W-1:0] inst_line,
    input  logic             inst_wi,
    input  logic             inst_known,
    input  logic             evict_valid,
    input  logic [IDX_W-1:0] evict_line,
    input  logic             evict_dirty,
    output logic             out_valid,
    output logic             out_wi,
    output logic             out_wb_req,
    output logic [1:0]       out_wb_reason
);
    import wi_pkg::*;

    logic               inst_high;
    logic [CNT_W-1:0]   vic_cnt;
    logic               vic_ibit;
    logic               dec_wi;
    logic               dec_wb;
    wb_reason_e         dec_reason;

    // Only a recovered high hint preloads the counter to its top.
    always_comb begin
        inst_high = inst_known && inst_wi;
    end

    wi_counter_bank #(
        .LINES (LINES),
        .CNT_W (CNT_W)
    ) u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .hit_valid    (hit_valid),
        .hit_line     (hit_line),
        .hit_is_write (hit_is_write),
        .inst_valid   (inst_valid),
        .inst_line    (inst_line),
        .inst_high    (inst_high),
        .rd_line      (evict_line),
        .rd_cnt       (vic_cnt),
        .rd_ibit      (vic_ibit)
    );

    wi_victim_classifier #(
        .CNT_W (CNT_W)
    ) u_class (
        .vic_cnt     (vic_cnt),
        .vic_ibit    (vic_ibit),
        .vic_dirty   (evict_dirty),
        .threshold   (cfg_threshold),
        .clean_wb_en (cfg_clean_wb_en),
        .wi_bit      (dec_wi),
        .wb_req      (dec_wb),
        .reason      (dec_reason)
    );

    // Eviction result register; fields are cleared when no request is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_wi        <= 1'b0;
            out_wb_req    <= 1'b0;
            out_wb_reason <= WB_NONE;
        end else if (evict_valid) begin
            out_valid     <= 1'b1;
            out_wi        <= dec_wi;
            out_wb_req    <= dec_wb;
            out_wb_reason <= dec_reason;
        end else begin
            out_valid     <= 1'b0;
            out_wi        <= 1'b0;
            out_wb_req    <= 1'b0;
            out_wb_reason <= WB_NONE;
        end
    end

endmodule

// File: rtl/wi_tracker_chk.sv
// Module: assertion checker for wi_tracker, attached by bind.
// Assumes configuration inputs are held steady around an eviction.
module wi_tracker_chk #(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cfg_threshold,
    input logic             cfg_clean_wb_en,
    input logic             evict_valid,
    input logic             evict_dirty,
    input logic             out_valid,
    input logic             out_wi,
    input logic             out_wb_req,
    input logic [1:0]       out_wb_reason
);

    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |=> out_valid); // R10

    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !evict_valid |=> !out_valid); // R10

    AST_IDLE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_wb_req); // R10

    AST_DIRTY_WRITES_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && evict_dirty) |=> (out_wb_req && out_wb_reason == 2'b01)); // R5

    AST_CLEAN_WB_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !evict_dirty && !cfg_clean_wb_en) |=> !out_wb_req); // R8

    AST_CLEAN_REASON_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && !evict_dirty) |=> (out_wb_reason != 2'b01)); // R6

    AST_NOTHING_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (evict_valid && cfg_threshold == CNT_TOP) |=> !out_wi); // R2

    AST_REASON_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_wb_req == (out_wb_reason != 2'b00))); // R7

endmodule

bind wi_tracker wi_tracker_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_threshold   (cfg_threshold),
    .cfg_clean_wb_en (cfg_clean_wb_en),
    .evict_valid     (evict_valid),
    .evict_dirty     (evict_dirty),
    .out_valid       (out_valid),
    .out_wi          (out_wi),
    .out_wb_req      (out_wb_req),
    .out_wb_reason   (out_wb_reason)
);

// File: tb/wi_tracker_tb.sv
// Directed bench for wi_tracker with a reference model of counters and install bits.
module wi_tracker_tb;

    localparam int LINES   = 64;
    localparam int CNT_W   = 3;
    localparam int IDX_W   = $clog2(LINES);
    localparam int CLK_PER = 10;
    localparam int MAXV    = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] cfg_threshold = '0;
    logic             cfg_clean_wb_en = 1'b1;
    logic             hit_valid = 1'b0;
    logic [IDX_W-1:0] hit_line = '0;
    logic             hit_is_write = 1'b0;
    logic             inst_valid = 1'b0;
    logic [IDX_W-1:0] inst_line = '0;
    logic             inst_wi = 1'b0;
    logic             inst_known = 1'b0;
    logic             evict_valid = 1'b0;
    logic [IDX_W-1:0] evict_line = '0;
    logic             evict_dirty = 1'b0;
    logic             out_valid;
    logic             out_wi;
    logic             out_wb_req;
    logic [1:0]       out_wb_reason;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    int m_cnt  [LINES];
    bit m_ibit [LINES];

    always #(CLK_PER/2) clk = ~clk;

    wi_tracker #(.LINES(LINES), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_threshold(cfg_threshold), .cfg_clean_wb_en(cfg_clean_wb_en),
        .hit_valid(hit_valid), .hit_line(hit_line), .hit_is_write(hit_is_write),
        .inst_valid(inst_valid), .inst_line(inst_line), .inst_wi(inst_wi),
        .inst_known(inst_known),
        .evict_valid(evict_valid), .evict_line(evict_line), .evict_dirty(evict_dirty),
        .out_valid(out_valid), .out_wi(out_wi), .out_wb_req(out_wb_req),
        .out_wb_reason(out_wb_reason)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Model update for a hit (R1).
    function automatic void m_hit(input int line, input bit wr);
        if (wr) m_cnt[line] = (m_cnt[line] >= MAXV) ? MAXV : m_cnt[line] + 1;
        else    m_cnt[line] = (m_cnt[line] == 0) ? 0 : m_cnt[line] - 1;
    endfunction

    // Model update for an install (R3, R4).
    function automatic void m_inst(input int line, input bit wi, input bit known);
        m_cnt[line]  = (known && wi) ? MAXV : 0;
        m_ibit[line] = known && wi;
    endfunction

    task automatic do_hit(input int line, input bit wr);
        hit_valid = 1'b1; hit_line = IDX_W'(line); hit_is_write = wr;
        @(negedge clk);
        hit_valid = 1'b0;
        m_hit(line, wr);
    endtask

    task automatic do_inst(input int line, input bit wi, input bit known);
        inst_valid = 1'b1; inst_line = IDX_W'(line); inst_wi = wi; inst_known = known;
        @(negedge clk);
        inst_valid = 1'b0;
        m_inst(line, wi, known);
    endtask

    // Eviction with expected values from the model; result sampled one cycle later.
    task automatic do_evict(input int line, input bit dirty, input string req);
        bit e_wi, e_wb;
        int e_rs;
        e_wi = (m_cnt[line] > int'(cfg_threshold));
        if (dirty) begin e_wb = 1; e_rs = 1; end
        else if (cfg_clean_wb_en && (e_wi != m_ibit[line])) begin e_wb = 1; e_rs = 2; end
        else begin e_wb = 0; e_rs = 0; end
        evict_valid = 1'b1; evict_line = IDX_W'(line); evict_dirty = dirty;
        @(negedge clk);
        evict_valid = 1'b0;
        chk({req, " R10 valid"}, int'(out_valid), 1);
        chk({req, " wi"}, int'(out_wi), int'(e_wi));
        chk({req, " wb_req"}, int'(out_wb_req), int'(e_wb));
        chk({req, " reason"}, int'(out_wb_reason), e_rs);
    endtask

    task automatic t_reset;
        chk("R10 reset valid", int'(out_valid), 0);
        chk("R10 reset wb_req", int'(out_wb_req), 0);
        cfg_threshold = 3'd3;
        do_evict(0, 1'b0, "R7 reset line clean");
        @(negedge clk);
        chk("R10 single-cycle result", int'(out_valid), 0);
    endtask

    task automatic t_saturate;
        for (int i = 0; i < 10; i++) do_hit(5, 1'b1);
        cfg_threshold = 3'd6;
        do_evict(5, 1'b1, "R1 up-saturate R5");
        for (int i = 0; i < 10; i++) do_hit(5, 1'b0);
        cfg_threshold = 3'd0;
        do_evict(5, 1'b1, "R1 down-saturate R2");
        do_hit(5, 1'b0);
        do_hit(5, 1'b1);
        do_evict(5, 1'b1, "R1 no wrap below zero");
    endtask

    task automatic t_threshold;
        for (int i = 0; i < 3; i++) do_hit(6, 1'b1);
        cfg_threshold = 3'd3;
        do_evict(6, 1'b1, "R2 equal is low");
        cfg_threshold = 3'd2;
        do_evict(6, 1'b1, "R2 above is high");
        cfg_threshold = 3'd7;
        do_evict(6, 1'b1, "R2 top threshold");
    endtask

    task automatic t_known_high;
        cfg_threshold = 3'd3;
        do_inst(7, 1'b1, 1'b1);
        do_evict(7, 1'b0, "R3 preset high R7 unchanged");
        for (int i = 0; i < 7; i++) do_hit(7, 1'b0);
        do_evict(7, 1'b0, "R6 flip high to low");
        cfg_clean_wb_en = 1'b0;
        do_evict(7, 1'b0, "R8 clean wb disabled");
        cfg_clean_wb_en = 1'b1;
    endtask

    task automatic t_unknown;
        cfg_threshold = 3'd3;
        do_hit(8, 1'b1); do_hit(8, 1'b1);
        do_inst(8, 1'b1, 1'b0);
        do_evict(8, 1'b0, "R4 unknown hint presets zero");
        for (int i = 0; i < 5; i++) do_hit(8, 1'b1);
        do_evict(8, 1'b0, "R6 flip low to high");
        cfg_clean_wb_en = 1'b0;
        do_evict(8, 1'b1, "R8 dirty still written R5");
        cfg_clean_wb_en = 1'b1;
        do_inst(8, 1'b0, 1'b1);
        do_evict(8, 1'b0, "R4 known low presets zero");
    endtask

    task automatic t_collide;
        inst_valid = 1'b1; inst_line = IDX_W'(9); inst_wi = 1'b1; inst_known = 1'b1;
        hit_valid = 1'b1; hit_line = IDX_W'(9); hit_is_write = 1'b0;
        @(negedge clk);
        inst_valid = 1'b0; hit_valid = 1'b0;
        m_inst(9, 1'b1, 1'b1);
        cfg_threshold = 3'd6;
        do_evict(9, 1'b1, "R9 install wins over hit");
    endtask

    task automatic t_isolation;
        cfg_threshold = 3'd0;
        do_inst(11, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) do_hit(10, 1'b1);
        do_inst(10, 1'b1, 1'b1);
        do_evict(12, 1'b0, "R11 neighbour untouched");
        do_evict(11, 1'b0, "R11 other line kept");
    endtask

    task automatic t_mixed;
        logic [15:0] lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cfg_threshold   = lf[2:0];
            cfg_clean_wb_en = lf[3] | lf[4];
            case (lf[6:5])
                2'd0, 2'd1: do_hit(int'(lf[9:8]) + 20, lf[10]);
                2'd2:       do_inst(int'(lf[9:8]) + 20, lf[11], lf[12]);
                default:    do_evict(int'(lf[9:8]) + 20, lf[13], "R1 R2 R5 R6 R7 mixed");
            endcase
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_cnt[i] = 0; m_ibit[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_saturate();
        t_threshold();
        t_known_high();
        t_unknown();
        t_collide();
        t_isolation();
        t_mixed();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule